// File: doc/BRIEF.md
# Table-Driven PLL Reconfiguration Sequencer

This block sits between software-style rate requests and a bank of three cascaded clock dividers that set a PLL's output: a reference (input) divider, a feedback divider and a post (output) divider. It holds a small built-in table of supported output rates, each tied to a divider triplet. The output rate follows reference × feedback / (input × output). A requester hands it a rate and an operation on a valid/ready port and gets one response pulse carrying a result code and a rate.

A set operation looks for an exact rate match. On a hit it writes the three encoded divider words through a simple write master. The first two words are marked "hold" and the last one clears that mark, which commits all three at once. The block then waits a fixed lock interval, samples the PLL status word and reports success, error or timeout. A query operation returns the closest supported rate without touching the dividers. A readback operation recomputes the rate from the ratios last committed, using a 64-bit multiply and divide.

Top module: `pll_reprog_seq`

## Requirements
- R1: Each divider word for ratio d has the low count ceil(d/2) in bits 5:0, the high count floor(d/2) in bits 11:6, bit 12 set when d is odd, bit 13 (bypass) set only when d = 1, bit 14 the hold flag, and bits 31:15 zero.
- R2: A matching set writes offset 0x0 (input divider), then 0x4 (feedback), then 0x8 (output) on three consecutive cycles, beginning the cycle after acceptance. The hold flag is set on the first two writes and clear on the third.
- R3: The response of a matching set appears exactly LOCK_CYCLES + 2 cycles after the commit write, where LOCK_CYCLES = CLK_HZ / 1,000,000 × LOCK_US (12,500 by default).
- R4: Status bit 0 is lock and bit 1 is error. Result codes are 0 = ok, 1 = invalid, 2 = timeout. If lock is clear the result is timeout; otherwise, if error is set, it is invalid; otherwise it is ok. rsp_rate carries the matched rate.
- R5: A set whose rate matches no entry, and any request with op code 3, responds invalid on the cycle after acceptance with rsp_rate 0, makes no divider write, and leaves the committed ratios unchanged.
- R6: A query (op 1) returns code ok and the entry with the smallest absolute distance to the requested rate; on a tie the lower table index wins. It makes no divider write and responds on the cycle after acceptance.
- R7: With no table entries enabled, a query responds invalid with rate 0, and every set responds invalid.
- R8: A readback (op 2) responds on the cycle after acceptance with code ok and floor(REF_HZ × fb / (in × out)) from the committed ratios. These are (1,1,1) after reset and take the written triplet at every commit, whatever the status outcome.
- R9: req_ready is high only while idle, so no request is taken until the current one has responded; rsp_valid is a single-cycle pulse.
- R10: After reset req_ready is 1 and wr_valid and rsp_valid are 0.

Op codes: 0 = set, 1 = query, 2 = readback. The default table, in index order, is: 33333333 (1,1,1), 50000000 (1,30,20), 75000000 (2,45,10), 90000000 (2,54,10), 100000000 (1,30,10), 125000000 (2,45,6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 2 | 0 set, 1 query, 2 readback |
| req_rate | input | 32 | Requested rate in Hz |
| wr_valid | output | 1 | Divider register write strobe |
| wr_addr | output | 4 | Divider register byte offset |
| wr_data | output | 32 | Encoded divider word |
| pll_status | input | 2 | Bit 0 lock, bit 1 error |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | Result code |
| rsp_rate | output | 32 | Matched, nearest or recomputed rate |

## Verification
Two outcomes can land on the same status sample: lock clear and error set. The bench drives status 2'b10 for one sequence to check that timeout takes priority, and 2'b11 for another to check that it yields invalid. The commit write and the ratio state that readback uses also coincide. After a timed-out or errored set, a readback shows whether the triplet was still committed, and after an unmatched set it shows that nothing changed. The reference model predicts every output on every cycle of each sequence, including the exact cycle of the response after the lock wait.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

    localparam int RATE_W = 32;
    localparam int DIV_W  = 8;
    localparam int WORD_W = 32;
    localparam int MAX_SLOTS = 6;

    localparam logic [1:0] OP_SET   = 2'd0;
    localparam logic [1:0] OP_QUERY = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    localparam logic [1:0] RES_OK      = 2'd0;
    localparam logic [1:0] RES_INVALID = 2'd1;
    localparam logic [1:0] RES_TIMEOUT = 2'd2;

    localparam logic [3:0] OFS_IN  = 4'h0;
    localparam logic [3:0] OFS_FB  = 4'h4;
    localparam logic [3:0] OFS_OUT = 4'h8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR_IN, ST_WR_FB, ST_WR_OUT, ST_WAIT, ST_CHECK, ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [DIV_W-1:0]  in_div;
        logic [DIV_W-1:0]  fb_div;
        logic [DIV_W-1:0]  out_div;
    } rate_entry_t;

    function automatic rate_entry_t table_entry(input int idx);
        rate_entry_t e;
        case (idx)
            0: e = '{32'd33333333,  8'd1, 8'd1,  8'd1};
            1: e = '{32'd50000000,  8'd1, 8'd30, 8'd20};
            2: e = '{32'd75000000,  8'd2, 8'd45, 8'd10};
            3: e = '{32'd90000000,  8'd2, 8'd54, 8'd10};
            4: e = '{32'd100000000, 8'd1, 8'd30, 8'd10};
            5: e = '{32'd125000000, 8'd2, 8'd45, 8'd6};
            default: e = '0;
        endcase
        return e;
    endfunction

    // low/high split of the ratio, odd flag, bypass for unity, hold flag
    function automatic logic [WORD_W-1:0] encode_div(input logic [DIV_W-1:0] d,
                                                     input logic hold);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[5:0]   = 6'((9'(d) + 9'd1) >> 1);
        w[11:6]  = 6'(d >> 1);
        w[12]    = d[0];
        w[13]    = (d == DIV_W'(1));
        w[14]    = hold;
        return w;
    endfunction

endpackage

// File: rtl/pll_rate_table.sv
module pll_rate_table
    import pll_reprog_pkg::*;
#(
    parameter int USE_ENTRIES = 6
) (
    input  logic [RATE_W-1:0] want,
    output logic              hit,
    output rate_entry_t       hit_entry,
    output logic              near_ok,
    output logic [RATE_W-1:0] near_rate
);
    localparam int ACTIVE = (USE_ENTRIES < MAX_SLOTS) ? USE_ENTRIES : MAX_SLOTS;

    rate_entry_t          slot [MAX_SLOTS];
    logic [MAX_SLOTS-1:0] live;
    logic [RATE_W-1:0]    best_gap;
    logic [RATE_W-1:0]    gap;

    genvar g;
    generate
        for (g = 0; g < MAX_SLOTS; g++) begin : g_slot
            if (g < ACTIVE) begin : g_on
                assign slot[g] = table_entry(g);
                assign live[g] = 1'b1;
            end else begin : g_off
                assign slot[g] = '0;
                assign live[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        hit       = 1'b0;
        hit_entry = '0;
        near_ok   = 1'b0;
        near_rate = '0;
        best_gap  = '1;
        gap       = '0;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            if (live[i]) begin
                if (!hit && slot[i].rate == want) begin
                    hit       = 1'b1;
                    hit_entry = slot[i];
                end
                gap = (slot[i].rate > want) ? slot[i].rate - want : want - slot[i].rate;
                // strict compare keeps the lower index on a tie
                if (!near_ok || gap < best_gap) begin
                    near_ok   = 1'b1;
                    best_gap  = gap;
                    near_rate = slot[i].rate;
                end
            end
        end
    end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_reprog_pkg::*;
#(
    parameter longint REF_HZ = 33333333,
    parameter int     CALC_W = 64
) (
    input  logic [DIV_W-1:0]  in_div,
    input  logic [DIV_W-1:0]  fb_div,
    input  logic [DIV_W-1:0]  out_div,
    output logic [RATE_W-1:0] rate
);
    logic [CALC_W-1:0] num;
    logic [CALC_W-1:0] den;

    always_comb begin
        num  = CALC_W'(REF_HZ) * CALC_W'(fb_div);
        den  = CALC_W'(in_div) * CALC_W'(out_div);
        rate = (den == '0) ? '0 : RATE_W'(num / den);
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter longint REF_HZ      = 33333333,
    parameter longint CLK_HZ      = 125000000,
    parameter int     LOCK_US     = 100,
    parameter int     USE_ENTRIES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [RATE_W-1:0] req_rate,
    output logic              wr_valid,
    output logic [3:0]        wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        pll_status,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [RATE_W-1:0] rsp_rate
);
    localparam int LOCK_CYCLES = int'(CLK_HZ / 1000000) * LOCK_US;
    localparam int CNT_W       = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        rate_entry_t       pend;
        logic [DIV_W-1:0]  act_in;
        logic [DIV_W-1:0]  act_fb;
        logic [DIV_W-1:0]  act_out;
        logic [1:0]        code;
        logic [RATE_W-1:0] rate;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              tbl_hit;
    rate_entry_t       tbl_entry;
    logic              near_ok;
    logic [RATE_W-1:0] near_rate;
    logic [RATE_W-1:0] calc_rate;

    pll_rate_table #(.USE_ENTRIES(USE_ENTRIES)) u_table (
        .want      (req_rate),
        .hit       (tbl_hit),
        .hit_entry (tbl_entry),
        .near_ok   (near_ok),
        .near_rate (near_rate)
    );

    pll_rate_calc #(.REF_HZ(REF_HZ)) u_calc (
        .in_div  (q.act_in),
        .fb_div  (q.act_fb),
        .out_div (q.act_out),
        .rate    (calc_rate)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_RESP;
                    d.code  = RES_INVALID;
                    d.rate  = '0;
                    case (req_op)
                        OP_SET: begin
                            if (tbl_hit) begin
                                d.state = ST_WR_IN;
                                d.pend  = tbl_entry;
                                d.rate  = tbl_entry.rate;
                            end
                        end
                        OP_QUERY: begin
                            d.code = near_ok ? RES_OK : RES_INVALID;
                            d.rate = near_rate;
                        end
                        OP_READ: begin
                            d.code = RES_OK;
                            d.rate = calc_rate;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WR_IN:  d.state = ST_WR_FB;
            ST_WR_FB:  d.state = ST_WR_OUT;
            ST_WR_OUT: begin
                d.state   = ST_WAIT;
                d.act_in  = q.pend.in_div;
                d.act_fb  = q.pend.fb_div;
                d.act_out = q.pend.out_div;
                d.cnt     = CNT_W'(LOCK_CYCLES - 1);
            end
            ST_WAIT: begin
                if (q.cnt == '0) d.state = ST_CHECK;
                else             d.cnt   = q.cnt - 1'b1;
            end
            ST_CHECK: begin
                d.state = ST_RESP;
                if (!pll_status[0])     d.code = RES_TIMEOUT;
                else if (pll_status[1]) d.code = RES_INVALID;
                else                    d.code = RES_OK;
            end
            ST_RESP:  d.state = ST_IDLE;
            default:  d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.act_in  <= DIV_W'(1);
            q.act_fb  <= DIV_W'(1);
            q.act_out <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready = (q.state == ST_IDLE);
        rsp_valid = (q.state == ST_RESP);
        rsp_code  = q.code;
        rsp_rate  = q.rate;
        wr_valid  = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        case (q.state)
            ST_WR_IN: begin
                wr_valid = 1'b1;
                wr_addr  = OFS_IN;
                wr_data  = encode_div(q.pend.in_div, 1'b1);
            end
            ST_WR_FB: begin
                wr_valid = 1'b1;
                wr_addr  = OFS_FB;
                wr_data  = encode_div(q.pend.fb_div, 1'b1);
            end
            ST_WR_OUT: begin
                wr_valid = 1'b1;
                wr_addr  = OFS_OUT;
                wr_data  = encode_div(q.pend.out_div, 1'b0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int LOCK_CYCLES = 12500
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        wr_valid,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        rsp_valid,
    input logic [1:0]  rsp_code
);
    logic        armed;
    logic [31:0] since;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            since <= '0;
        end else if (wr_valid && wr_addr == 4'h8) begin
            armed <= 1'b1;
            since <= '0;
        end else if (rsp_valid) begin
            armed <= 1'b0;
        end else if (armed) begin
            since <= since + 1;
        end
    end

    a_r2_fb_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr == 4'h0 |=> wr_valid && wr_addr == 4'h4);
    a_r2_out_follows_fb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr == 4'h4 |=> wr_valid && wr_addr == 4'h8);
    a_r2_hold_on_early: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr != 4'h8 |-> wr_data[14]);
    a_r2_commit_clears_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr == 4'h8 |-> !wr_data[14]);
    a_r1_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[31:15] == 17'd0);
    a_r3_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && armed |-> since == 32'(LOCK_CYCLES + 1));
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code != 2'd3);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);
    a_r9_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code)
);

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
    localparam longint REF = 33333333;
    localparam int LOCK = 125 * 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = '0;
    logic [31:0] req_rate = '0;
    logic        wr_valid;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  pll_status = 2'b01;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rate;

    logic        e_valid = 1'b0, e_ready;
    logic [1:0]  e_op = '0;
    logic [31:0] e_rate = '0;
    logic        e_wr_valid;
    logic [3:0]  e_wr_addr;
    logic [31:0] e_wr_data;
    logic        e_rsp_valid;
    logic [1:0]  e_rsp_code;
    logic [31:0] e_rsp_rate;

    pll_reprog_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_rate(req_rate), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .pll_status(pll_status), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_rate(rsp_rate));

    pll_reprog_seq #(.USE_ENTRIES(0)) uut_empty (
        .clk(clk), .rst_n(rst_n), .req_valid(e_valid), .req_ready(e_ready),
        .req_op(e_op), .req_rate(e_rate), .wr_valid(e_wr_valid), .wr_addr(e_wr_addr),
        .wr_data(e_wr_data), .pll_status(2'b01), .rsp_valid(e_rsp_valid),
        .rsp_code(e_rsp_code), .rsp_rate(e_rsp_rate));

    int checks = 0, fails = 0;
    bit finished = 0;

    int rates[6] = '{33333333, 50000000, 75000000, 90000000, 100000000, 125000000};
    int ins[6]   = '{1, 2, 2, 2, 1, 2};
    int fbs[6]   = '{1, 30, 45, 54, 30, 45};
    int outs[6]  = '{1, 20, 10, 10, 10, 6};
    int cur_in = 1, cur_fb = 1, cur_out = 1;

    initial begin
        ins[1] = 1;
    end

    function automatic logic [31:0] model_word(input int dv, input bit hold);
        logic [31:0] w = 0;
        w = 32'((dv + 1) / 2) | (32'(dv / 2) << 6) | (32'(dv % 2) << 12)
          | (32'(dv == 1) << 13) | (32'(hold) << 14);
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // issue one request and compare every output on every cycle until the response
    task automatic run(input int op, input int rate, input logic [1:0] st, input string tag);
        int idx = -1;
        int n;
        int exp_code = 1;
        longint exp_rate = 0;
        for (int i = 0; i < 6; i++) if (idx < 0 && op == 0 && rates[i] == rate) idx = i;
        if (op == 0 && idx >= 0) begin
            n = LOCK + 5;
            exp_rate = rates[idx];
            exp_code = !st[0] ? 2 : (st[1] ? 1 : 0);
        end else if (op == 1) begin
            longint best = -1;
            n = 1; exp_code = 0;
            for (int i = 0; i < 6; i++) begin
                longint gp = (rates[i] > rate) ? longint'(rates[i]) - rate : longint'(rate) - rates[i];
                if (best < 0 || gp < best) begin best = gp; exp_rate = rates[i]; end
            end
        end else if (op == 2) begin
            n = 1; exp_code = 0;
            exp_rate = (REF * cur_fb) / (cur_in * cur_out);
        end else begin
            n = 1;
        end
        @(negedge clk);
        check(req_ready === 1'b1, {tag, " R9 ready idle"}, req_ready, 1);
        req_op = 2'(op); req_rate = rate; pll_status = st; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < n; c++) begin
            bit ew = (n > 1) && (c < 3);
            logic [31:0] ed = 0;
            int ea = 4 * c;
            bit er = (c == n - 1);
            if (ew) ed = model_word(c == 0 ? ins[idx] : (c == 1 ? fbs[idx] : outs[idx]), c < 2);
            check(wr_valid === ew && req_ready === 1'b0 && rsp_valid === er,
                  {tag, " R2/R3/R5/R9 strobes"}, {wr_valid, req_ready, rsp_valid}, {ew, 1'b0, er});
            if (ew) begin
                check(wr_addr === 4'(ea) && wr_data === ed, {tag, " R1/R2 word"}, wr_data, ed);
            end
            if (er) begin
                check(rsp_code === 2'(exp_code), {tag, " R4 code"}, rsp_code, exp_code);
                check(rsp_rate === 32'(exp_rate), {tag, " R6/R8 rate"}, rsp_rate, exp_rate);
            end
            if (c < n - 1) @(negedge clk);
        end
        if (n > 1) begin cur_in = ins[idx]; cur_fb = fbs[idx]; cur_out = outs[idx]; end
        @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, {tag, " R9 back idle"}, rsp_valid, 0);
    endtask

    task automatic run_empty(input int op, input int rate, input string tag);
        @(negedge clk);
        e_op = 2'(op); e_rate = rate; e_valid = 1'b1;
        @(negedge clk);
        e_valid = 1'b0;
        check(e_rsp_valid === 1'b1 && e_wr_valid === 1'b0, {tag, " R7 strobe"}, e_rsp_valid, 1);
        check(e_rsp_code === 2'd1 && e_rsp_rate === 0, {tag, " R7 invalid"}, e_rsp_code, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready === 1'b1 && wr_valid === 1'b0 && rsp_valid === 1'b0,
              "R10 reset state", {req_ready, wr_valid, rsp_valid}, 3'b100);
        rst_n = 1'b1;
        run(2, 0, 2'b01, "R8 readback after reset");
        run(0, 100000000, 2'b01, "R1 R2 R3 R4 set ok");
        run(2, 0, 2'b01, "R8 readback 100M");
        run(0, 75000000, 2'b10, "R4 timeout beats error");
        run(2, 0, 2'b01, "R8 readback after timeout");
        run(0, 125000000, 2'b11, "R4 error invalid");
        run(0, 33333333, 2'b01, "R1 bypass words");
        run(0, 60000000, 2'b01, "R5 unmatched set");
        run(2, 0, 2'b01, "R5 ratios unchanged");
        run(3, 50000000, 2'b01, "R5 reserved op");
        run(1, 62500000, 2'b01, "R6 tie earlier");
        run(1, 82500000, 2'b01, "R6 tie 75 vs 90");
        run(1, 0, 2'b01, "R6 below table");
        run(1, 200000000, 2'b01, "R6 above table");
        run(1, 91000000, 2'b01, "R6 near 90");
        run_empty(1, 50000000, "R7 empty query");
        run_empty(0, 50000000, "R7 empty set");
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule